// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a bus-mapped watchdog. A down-counter is armed with a programmed reload value. While the interrupt enable is set, the counter steps down by one every clock. When it has reached zero it flags a pending interrupt and starts again from the reload value. If software never services that interrupt and the counter runs out a second time, the block can raise a sticky reset request for the rest of the system. Only a block reset clears that request.

All registers are protected against stray software stores. A store to any register other than the lock register takes effect only after the unlock key 0x1ACCE551 has been written to the lock register. Writing any other value to the lock register closes it again. Software therefore opens the register file, services or reprograms the watchdog, and closes it.

The bus is a simple single-cycle port. A write happens on the rising edge at which the write strobe is high. Read data is a combinational function of the address.

Top module: `guard_timer`

## Requirements
- R1: After reset the lock register reads 0 (open), the reload register and the count read 0xFFFFFFFF, the control register reads 0, raw status reads 0, and both irqOut and rstReqOut are low.
- R2: Writing 0x1ACCE551 to the lock register at byte address 0xC00 opens the registers, and writing any other value closes them. Reading the lock register returns 0 when open and 1 when closed.
- R3: While the registers are closed, writes to reload (0x000), control (0x008) and interrupt clear (0x00C) leave the reload value, the count, the control bits and the pending interrupt unchanged.
- R4: Control (0x008) bit 0 is the interrupt enable and bit 1 is the reset enable. When bit 0 changes from 0 to 1, the count (read at 0x004) is loaded from the reload value. While bit 0 is 1 the count falls by one per clock. While bit 0 is 0 the count holds.
- R5: If the count is zero on an edge while the interrupt enable is set, the interrupt becomes pending on that edge and the count is reloaded. With reload value N, the interrupt becomes pending N+1 edges after the enabling write.
- R6: Raw status (0x010) bit 0 shows the pending interrupt. Masked status (0x014) bit 0 shows pending AND interrupt enable, and irqOut equals the masked bit.
- R7: A write of any data to interrupt clear (0x00C) clears the pending interrupt and reloads the count from the reload value.
- R8: A write to the reload register sets both the reload value and the count to the written data.
- R9: An expiry that finds the interrupt still pending while the reset enable is set raises rstReqOut. rstReqOut then stays high until the block reset. With the reset enable clear, a second expiry leaves rstReqOut low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte address of the access |
| busWrite | input | 1 | Write strobe for one cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| irqOut | output | 1 | Masked watchdog interrupt |
| rstReqOut | output | 1 | Sticky reset request |

## Verification
The assertions assume that busAddr is word aligned and that busWrite lasts exactly one clock per access. They also assume that rstN is held low for at least one edge before any checking starts. The bench drives every access in a task that raises busWrite for a single edge at an aligned address. It changes inputs only on falling edges, and it holds reset for several cycles at the start and again before the reset-request scenario is repeated.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_RELOAD = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'hC00;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic writeReload; // latch new reload value, count takes it too
    logic loadCount;   // count <= reload value
    logic decCount;    // count <= count - 1
  } countCmd_t;
endpackage

// File: rtl/gtmr_ctrl.sv
module gtmr_ctrl
  import gtmr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWrite,
  input  logic [DW-1:0] busWdata,
  input  logic          countZero,
  output countCmd_t     cmd,
  output logic          intEn,
  output logic          rstEn,
  output logic          pending,
  output logic          unlocked,
  output logic          rstReq
);
  logic [AW-1:0] wordAddr;
  logic wrLock, wrAllowed, wrReload, wrCtrl, wrClear, expire;
  logic intEnQ, rstEnQ, pendingQ, unlockedQ, rstReqQ;

  assign wordAddr  = {busAddr[AW-1:2], 2'b00};
  assign wrLock    = busWrite && (wordAddr == OFS_LOCK);
  assign wrAllowed = busWrite && unlockedQ;
  assign wrReload  = wrAllowed && (wordAddr == OFS_RELOAD);
  assign wrCtrl    = wrAllowed && (wordAddr == OFS_CTRL);
  assign wrClear   = wrAllowed && (wordAddr == OFS_CLEAR);
  assign expire    = intEnQ && countZero;

  always_comb begin
    cmd.writeReload = wrReload;
    cmd.loadCount   = (wrCtrl && busWdata[0] && !intEnQ) || wrClear || expire;
    cmd.decCount    = intEnQ && !countZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unlockedQ <= 1'b1;
      intEnQ    <= 1'b0;
      rstEnQ    <= 1'b0;
      pendingQ  <= 1'b0;
      rstReqQ   <= 1'b0;
    end else begin
      if (wrLock) unlockedQ <= (busWdata == UNLOCK_KEY);
      if (wrCtrl) begin
        intEnQ <= busWdata[0];
        rstEnQ <= busWdata[1];
      end
      if (wrClear)     pendingQ <= 1'b0;
      else if (expire) pendingQ <= 1'b1;
      if (expire && pendingQ && rstEnQ && !wrClear) rstReqQ <= 1'b1;
    end
  end

  assign intEn    = intEnQ;
  assign rstEn    = rstEnQ;
  assign pending  = pendingQ;
  assign unlocked = unlockedQ;
  assign rstReq   = rstReqQ;

  // R3: a store to control while closed changes nothing
  assert_locked_ctrl_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && !unlockedQ && wordAddr == OFS_CTRL) |=> ($stable(intEnQ) && $stable(rstEnQ)));
  // R3: a clear while closed keeps the pending flag
  assert_locked_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && !unlockedQ && wordAddr == OFS_CLEAR && pendingQ) |=> pendingQ);
  // R5: expiry without a clear leaves the interrupt pending
  assert_expiry_pending_R5: assert property (@(posedge clk) disable iff (!rstN)
    (intEnQ && countZero && !wrClear) |=> pendingQ);
  // R9: reset request is sticky
  assert_reset_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    rstReqQ |=> rstReqQ);
  // R9: reset request only follows an unserviced interrupt with reset enabled
  assert_reset_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReqQ) |-> ($past(pendingQ) && $past(rstEnQ)));
endmodule

// File: rtl/gtmr_datapath.sv
module gtmr_datapath
  import gtmr_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  countCmd_t     cmd,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] reloadVal,
  output logic [DW-1:0] countVal,
  output logic          countZero
);
  localparam logic [DW-1:0] RESET_LOAD = {DW{1'b1}};

  logic [DW-1:0] reloadQ, countQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ <= RESET_LOAD;
      countQ  <= RESET_LOAD;
    end else if (cmd.writeReload) begin
      reloadQ <= busWdata;
      countQ  <= busWdata;
    end else if (cmd.loadCount) begin
      countQ <= reloadQ;
    end else if (cmd.decCount) begin
      countQ <= countQ - 1'b1;
    end
  end

  assign reloadVal = reloadQ;
  assign countVal  = countQ;
  assign countZero = (countQ == '0);

  // R4: a pure decrement step lowers the count by exactly one
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.decCount && !cmd.loadCount && !cmd.writeReload) |=> (countQ == $past(countQ) - 1'b1));
  // R4: with no strobe the count holds
  assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.decCount && !cmd.loadCount && !cmd.writeReload) |=> $stable(countQ));
  // R8: a reload store lands in both registers
  assert_reload_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.writeReload |=> (countQ == reloadQ));
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import gtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              rstReqOut
);
  countCmd_t         cmd;
  logic              intEn, rstEn, pending, unlocked, rstReq, countZero;
  logic [DATA_W-1:0] reloadVal, countVal;
  logic [ADDR_W-1:0] wordAddr;
  logic              maskedIrq;

  gtmr_ctrl #(.AW(ADDR_W), .DW(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .countZero(countZero), .cmd(cmd), .intEn(intEn),
    .rstEn(rstEn), .pending(pending), .unlocked(unlocked), .rstReq(rstReq)
  );

  gtmr_datapath #(.DW(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .busWdata(busWdata),
    .reloadVal(reloadVal), .countVal(countVal), .countZero(countZero)
  );

  assign wordAddr  = {busAddr[ADDR_W-1:2], 2'b00};
  assign maskedIrq = pending && intEn;

  always_comb begin
    busRdata = '0;
    case (wordAddr)
      OFS_RELOAD: busRdata = reloadVal;
      OFS_COUNT:  busRdata = countVal;
      OFS_CTRL:   busRdata[1:0] = {rstEn, intEn};
      OFS_RAW:    busRdata[0] = pending;
      OFS_MASKED: busRdata[0] = maskedIrq;
      OFS_LOCK:   busRdata[0] = !unlocked;
      default:    busRdata = '0;
    endcase
  end

  assign irqOut    = maskedIrq;
  assign rstReqOut = rstReq;

  // R6: the interrupt pin never shows while the enable is off
  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> intEn);
endmodule

// File: tb/guard_timer_test.sv
module guard_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, rstReqOut;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 0;

  guard_timer uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .rstReqOut(rstReqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic expectEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrite = 1'b0; busAddr = '0; busWdata = '0;
  endtask

  task automatic busRd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    waitEdges(3);
    rstN = 1'b1;
  endtask

  task automatic testResetState();
    logic [31:0] v;
    busRd(12'hC00, v); expectEq("R1 lock open", v, 0);
    busRd(12'h000, v); expectEq("R1 reload", v, 32'hFFFF_FFFF);
    busRd(12'h004, v); expectEq("R1 count", v, 32'hFFFF_FFFF);
    busRd(12'h008, v); expectEq("R1 control", v, 0);
    busRd(12'h010, v); expectEq("R1 raw", v, 0);
    expectEq("R1 irq", {31'b0, irqOut}, 0);
    expectEq("R1 rstReq", {31'b0, rstReqOut}, 0);
  endtask

  task automatic testLock();
    logic [31:0] v;
    busWr(12'hC00, 32'h1234_5678);
    busRd(12'hC00, v); expectEq("R2 closed readback", v, 1);
    busWr(12'h000, 32'h55);
    busRd(12'h000, v); expectEq("R3 reload ignored", v, 32'hFFFF_FFFF);
    busRd(12'h004, v); expectEq("R3 count ignored", v, 32'hFFFF_FFFF);
    busWr(12'h008, 32'h3);
    busRd(12'h008, v); expectEq("R3 control ignored", v, 0);
    busWr(12'hC00, 32'h1ACC_E551);
    busRd(12'hC00, v); expectEq("R2 open readback", v, 0);
  endtask

  task automatic testCountdown();
    logic [31:0] v;
    busWr(12'h000, 32'd5);
    busRd(12'h004, v); expectEq("R8 count follows reload", v, 5);
    busWr(12'h008, 32'h1);
    busRd(12'h004, v); expectEq("R4 loaded on enable", v, 5);
    waitEdges(5);
    busRd(12'h004, v); expectEq("R4 count reached zero", v, 0);
    busRd(12'h010, v); expectEq("R5 not yet pending", v, 0);
    waitEdges(1);
    busRd(12'h010, v); expectEq("R5 pending after N+1", v, 1);
    busRd(12'h014, v); expectEq("R6 masked set", v, 1);
    expectEq("R6 irq pin", {31'b0, irqOut}, 1);
    busRd(12'h004, v); expectEq("R5 reloaded at expiry", v, 5);
  endtask

  task automatic testClear();
    logic [31:0] v;
    waitEdges(2);
    busWr(12'h00C, 32'hDEAD_BEEF);
    busRd(12'h010, v); expectEq("R7 pending cleared", v, 0);
    busRd(12'h004, v); expectEq("R7 count reloaded", v, 5);
    expectEq("R7 irq low", {31'b0, irqOut}, 0);
  endtask

  task automatic testStopRestart();
    logic [31:0] v;
    busWr(12'h008, 32'h0);
    busWr(12'h000, 32'd10);
    busWr(12'h008, 32'h1);
    waitEdges(3);
    busRd(12'h004, v); expectEq("R4 decrementing", v, 7);
    busWr(12'h008, 32'h0);
    busRd(12'h004, v); expectEq("R4 last step on disable", v, 6);
    waitEdges(5);
    busRd(12'h004, v); expectEq("R4 held while disabled", v, 6);
    busWr(12'h008, 32'h1);
    busRd(12'h004, v); expectEq("R4 restart from reload", v, 10);
  endtask

  task automatic testMaskedAndLockedClear();
    logic [31:0] v;
    waitEdges(11);
    busRd(12'h010, v); expectEq("R5 pending again", v, 1);
    busWr(12'h008, 32'h0);
    busRd(12'h010, v); expectEq("R6 raw while disabled", v, 1);
    busRd(12'h014, v); expectEq("R6 masked while disabled", v, 0);
    expectEq("R6 irq pin masked", {31'b0, irqOut}, 0);
    busWr(12'hC00, 32'h0);
    busWr(12'h00C, 32'h0);
    busRd(12'h010, v); expectEq("R3 clear ignored when closed", v, 1);
    busWr(12'hC00, 32'h1ACC_E551);
    busWr(12'h00C, 32'h0);
    busRd(12'h010, v); expectEq("R7 clear after reopen", v, 0);
  endtask

  task automatic testNoResetWhenDisabled();
    logic [31:0] v;
    busWr(12'h000, 32'd3);
    busWr(12'h008, 32'h1);
    waitEdges(9);
    busRd(12'h010, v); expectEq("R9 raw pending", v, 1);
    expectEq("R9 no reset without enable", {31'b0, rstReqOut}, 0);
  endtask

  task automatic testResetRequest();
    doReset();
    busWr(12'h000, 32'd3);
    busWr(12'h008, 32'h3);
    waitEdges(7);
    expectEq("R9 reset not before second expiry", {31'b0, rstReqOut}, 0);
    waitEdges(1);
    expectEq("R9 reset raised", {31'b0, rstReqOut}, 1);
    busWr(12'h00C, 32'h0);
    busWr(12'h008, 32'h0);
    waitEdges(3);
    expectEq("R9 reset sticky", {31'b0, rstReqOut}, 1);
    doReset();
    expectEq("R9 cleared by block reset", {31'b0, rstReqOut}, 0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  endtask

  initial begin
    waitEdges(4);
    rstN = 1'b1;
    testResetState();
    testLock();
    testCountdown();
    testClear();
    testStopRestart();
    testMaskedAndLockedClear();
    testNoResetWhenDisabled();
    testResetRequest();
    finish();
  end

  initial begin
    for (int i = 0; i < WATCHDOG_CYCLES; i++) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end
endmodule